// File: doc/BRIEF.md
# Packed SIMD Rounding and Saturating Shifter

This block shifts a 32-bit word that holds either four 8-bit lanes or two 16-bit lanes. Every lane moves by the same amount. Three shift kinds are available: arithmetic right, logical right and logical left. The amount comes either from the low bits of a second data operand or from a small immediate field.

The lane width is not a separate control input. It comes from the register indices that go with the operation. Indices in the lower band select 8-bit lanes and indices in the upper band select 16-bit lanes. An index outside both bands, or indices that fall in different bands, make the operation illegal.

One mode bit selects the variant. With the bit set, a right shift rounds and a left shift saturates. The result, a saturation flag and an illegal flag are registered. They appear one cycle after the operation is presented.

Top module: `psimd_shift`

## Requirements
- R1: Indices 2 to 15 select 8-bit lanes and indices 16 to 29 select 16-bit lanes. The width decode checks `dst_idx` and `src1_idx` in every form, and also `src2_idx` when `use_imm` is 0.
- R2: `illegal` is 1 and `result` and `sat` are 0 in the following cases:
  - a checked index lies outside 2 to 29;
  - the checked indices fall in different width classes;
  - `kind` is 2'b11;
  - `mode[1]` is 1.
- R3: The `kind` encoding is 2'b00 arithmetic right, 2'b01 logical right and 2'b10 logical left. The shift amount is the low 3 bits (8-bit lanes) or the low 4 bits (16-bit lanes) of the amount source. The same amount applies to every lane.
- R4: When `use_imm` is 1, the amount comes from `imm` and `opb` has no effect.
- R5: A right shift with `mode` = 2'b01 adds the last bit shifted out to the truncated lane result. With an amount of zero the lane is returned unchanged.
- R6: A left shift with `mode` = 2'b01 treats each lane as signed. If significant bits would be lost, the lane clamps to the signed maximum (0x7F / 0x7FFF) or the signed minimum (0x80 / 0x8000), following the sign of the input lane. `sat` is the OR over the lanes that clamped.
- R7: A plain left shift (`mode` = 2'b00) discards the bits shifted out. No right shift and no plain left shift ever sets `sat`.
- R8: The outputs update on the clock edge that samples `in_valid` = 1. `out_valid` is high for exactly the following cycle. While `in_valid` is 0, `result`, `sat` and `illegal` hold their values.
- R9: During reset, `out_valid`, `result`, `sat` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| kind | input | 2 | Shift kind |
| mode | input | 2 | Variant select (bit 0: round/saturate) |
| use_imm | input | 1 | Take the amount from `imm` |
| dst_idx | input | 5 | Destination register index |
| src1_idx | input | 5 | First source register index |
| src2_idx | input | 5 | Second source register index |
| opa | input | 32 | Packed operand to shift |
| opb | input | 32 | Amount operand (register form) |
| imm | input | 4 | Immediate amount |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Shifted packed word |
| sat | output | 1 | A lane saturated |
| illegal | output | 1 | Operation rejected |

## Verification
Each shift kind is tried on lanes that hold the extreme values (sign boundary, all ones, small odd numbers), at both lane widths. This shows whether the sign is carried into vacated bits and whether lanes stay isolated.

Two pairs of runs use the same operand and amount:
- rounding against plain right shifts, which shows whether the last bit out is counted and whether an amount of zero is left alone;
- saturating against plain left shifts, where only one lane overflows, which shows the clamp direction and that the flag follows the overflowing lane.

Amount operands with upper bits set separate masking to 3 or 4 bits from a full-width amount. Immediate runs with a junk second operand and an out-of-band `src2_idx` show that the second operand is ignored. Each illegal cause is applied on its own.

// File: rtl/psimd_shift_pkg.sv
package psimd_shift_pkg;

  typedef enum logic [1:0] {
    SH_SRA = 2'b00,
    SH_SRL = 2'b01,
    SH_SLL = 2'b10,
    SH_RSV = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    LC_BAD  = 2'b00,
    LC_NARR = 2'b01,
    LC_WIDE = 2'b10
  } lane_cls_e;

endpackage

// File: rtl/pshift_decode.sv
module pshift_decode
  import psimd_shift_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NARR_LO = 2,
  parameter int NARR_HI = 15,
  parameter int WIDE_LO = 16,
  parameter int WIDE_HI = 29
) (
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src1_idx,
  input  logic [IDX_W-1:0] src2_idx,
  input  logic             use_imm,
  input  logic [1:0]       kind,
  input  logic [1:0]       mode,
  output logic             legal,
  output logic             wide
);

  function automatic lane_cls_e classify(input logic [IDX_W-1:0] idx);
    if (int'(idx) >= NARR_LO && int'(idx) <= NARR_HI) return LC_NARR;
    if (int'(idx) >= WIDE_LO && int'(idx) <= WIDE_HI) return LC_WIDE;
    return LC_BAD;
  endfunction

  lane_cls_e cls_dst, cls_s1, cls_s2;

  always_comb begin
    cls_dst = classify(dst_idx);
    cls_s1  = classify(src1_idx);
    cls_s2  = classify(src2_idx);
    legal   = (cls_dst != LC_BAD) &&
              (cls_s1 == cls_dst) &&
              (use_imm || (cls_s2 == cls_dst)) &&
              (kind != SH_RSV) &&
              !mode[1];
    wide    = (cls_dst == LC_WIDE);
  end

endmodule

// File: rtl/pshift_lane.sv
module pshift_lane
  import psimd_shift_pkg::*;
#(
  parameter int W  = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    kind,
  input  logic          alt,
  output logic [W-1:0]  y,
  output logic          sat
);

  logic signed [W-1:0] sx;
  logic signed [W-1:0] back;
  logic        [W-1:0] shl;
  logic        [W-1:0] tail;
  logic                rbit;

  always_comb begin
    sx   = x;
    tail = '0;
    rbit = 1'b0;
    if (amt != '0) begin
      tail = x >> (amt - 1'b1);
      rbit = tail[0];
    end
    shl  = x << amt;
    back = $signed(shl) >>> amt;
    sat  = 1'b0;
    y    = '0;
    case (shift_kind_e'(kind))
      SH_SRA: begin
        y = sx >>> amt;
        if (alt) y = y + {{(W-1){1'b0}}, rbit};
      end
      SH_SRL: begin
        y = x >> amt;
        if (alt) y = y + {{(W-1){1'b0}}, rbit};
      end
      SH_SLL: begin
        y = shl;
        if (alt && (back != sx)) begin
          sat = 1'b1;
          y   = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
      end
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/psimd_shift.sv
module psimd_shift
  import psimd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NARR_W = 8,
  parameter int WIDE_W = 16,
  parameter int IDX_W  = 5,
  parameter int IMM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        kind,
  input  logic [1:0]        mode,
  input  logic              use_imm,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src1_idx,
  input  logic [IDX_W-1:0]  src2_idx,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              sat,
  output logic              illegal
);

  localparam int N_NARR = DATA_W / NARR_W;
  localparam int N_WIDE = DATA_W / WIDE_W;
  localparam int AW_N   = $clog2(NARR_W);
  localparam int AW_W   = $clog2(WIDE_W);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic legal, wide;
  pshift_decode #(.IDX_W(IDX_W)) u_dec (
    .dst_idx (dst_idx),
    .src1_idx(src1_idx),
    .src2_idx(src2_idx),
    .use_imm (use_imm),
    .kind    (kind),
    .mode    (mode),
    .legal   (legal),
    .wide    (wide)
  );

  logic [IMM_W-1:0] amt_src;
  assign amt_src = use_imm ? imm : opb[IMM_W-1:0];

  logic [DATA_W-1:0] res_narr, res_wide;
  logic [N_NARR-1:0] sat_narr;
  logic [N_WIDE-1:0] sat_wide;

  for (genvar i = 0; i < N_NARR; i++) begin : g_narr
    pshift_lane #(.W(NARR_W)) u_lane (
      .x   (opa[i*NARR_W +: NARR_W]),
      .amt (amt_src[AW_N-1:0]),
      .kind(kind),
      .alt (mode[0]),
      .y   (res_narr[i*NARR_W +: NARR_W]),
      .sat (sat_narr[i])
    );
  end

  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    pshift_lane #(.W(WIDE_W)) u_lane (
      .x   (opa[j*WIDE_W +: WIDE_W]),
      .amt (amt_src[AW_W-1:0]),
      .kind(kind),
      .alt (mode[0]),
      .y   (res_wide[j*WIDE_W +: WIDE_W]),
      .sat (sat_wide[j])
    );
  end

  logic [DATA_W-1:0] res_d;
  logic              sat_d, ill_d;

  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    ill_d = !legal;
    if (legal) begin
      res_d = wide ? res_wide : res_narr;
      sat_d = wide ? |sat_wide : |sat_narr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat       <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        sat     <= sat_d;
        illegal <= ill_d;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(result) && $stable(sat) && $stable(illegal)));
  // R2
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (result == '0 && !sat));
  // R7
  sat_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !(kind == SH_SLL && mode == 2'b01)) |=> !sat);
  // R4
  imm_ignores_b_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (use_imm && $stable(use_imm) && $stable(imm) && $stable(opa) && $stable(kind) &&
     $stable(mode) && $stable(dst_idx) && $stable(src1_idx)) |-> $stable(res_d));

endmodule

// File: tb/test_psimd_shift.sv
`timescale 1ns/1ps
module test_psimd_shift;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  kind, mode;
  logic        use_imm;
  logic [4:0]  dst_idx, src1_idx, src2_idx;
  logic [31:0] opa, opb;
  logic [3:0]  imm;
  logic        out_valid, sat, illegal;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  psimd_shift i_psimd_shift (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind), .mode(mode),
    .use_imm(use_imm), .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx),
    .opa(opa), .opb(opb), .imm(imm), .out_valid(out_valid), .result(result),
    .sat(sat), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: lane arithmetic on signed integers
  function automatic logic [32:0] model(input logic [1:0] k, input logic alt,
                                        input bit w16, input int amt_raw,
                                        input logic [31:0] a);
    int w = w16 ? 16 : 8;
    int n = amt_raw & (w - 1);
    longint maxv = (64'sd1 <<< (w - 1)) - 1;
    longint minv = -(64'sd1 <<< (w - 1));
    longint mask = (64'sd1 <<< w) - 1;
    logic [31:0] res = '0;
    logic s = 1'b0;
    for (int i = 0; i < 32 / w; i++) begin
      longint uv = (longint'(a) >> (i * w)) & mask;
      longint sv = (uv > maxv) ? uv - (mask + 1) : uv;
      longint r  = 0;
      longint half = (n > 0) ? (64'sd1 <<< (n - 1)) : 0;
      case (k)
        2'b00: r = (alt ? sv + half : sv) >>> n;
        2'b01: r = (alt ? uv + half : uv) >>> n;
        default: begin
          longint p = sv * (64'sd1 <<< n);
          if (alt && p > maxv) begin r = maxv; s = 1'b1; end
          else if (alt && p < minv) begin r = minv; s = 1'b1; end
          else r = p;
        end
      endcase
      res = res | (32'(r & mask) << (i * w));
    end
    return {s, res};
  endfunction

  task automatic issue(input logic [1:0] k, input logic [1:0] m, input logic imf,
                       input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
                       input logic [31:0] a, input logic [31:0] b, input logic [3:0] im);
    @(negedge clk);
    kind = k; mode = m; use_imm = imf; dst_idx = rd; src1_idx = r1; src2_idx = r2;
    opa = a; opb = b; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_legal(input string req, input logic [1:0] k, input logic [1:0] m,
                           input logic imf, input logic [4:0] rd, input logic [4:0] r1,
                           input logic [4:0] r2, input logic [31:0] a,
                           input logic [31:0] b, input logic [3:0] im);
    logic [32:0] e;
    issue(k, m, imf, rd, r1, r2, a, b, im);
    e = model(k, m[0], rd >= 16, imf ? int'(im) : int'(b[3:0]), a);
    chk({req, " result"}, result, e[31:0]);
    chk({req, " sat"}, 32'(sat), 32'(e[32]));
    chk({req, " illegal"}, 32'(illegal), 32'd0);
  endtask

  task automatic run_illegal(input string req, input logic [1:0] k, input logic [1:0] m,
                             input logic imf, input logic [4:0] rd, input logic [4:0] r1,
                             input logic [4:0] r2);
    issue(k, m, imf, rd, r1, r2, 32'h4000_C07F, 32'h1, 4'h1);
    chk({req, " illegal flag"}, 32'(illegal), 32'd1);
    chk({req, " illegal result"}, result, 32'd0);
    chk({req, " illegal sat"}, 32'(sat), 32'd0);
  endtask

  task automatic t_reset;
    chk("R9 out_valid", 32'(out_valid), 32'd0);
    chk("R9 result", result, 32'd0);
    chk("R9 sat", 32'(sat), 32'd0);
    chk("R9 illegal", 32'(illegal), 32'd0);
  endtask

  task automatic t_kinds;
    run_legal("R3 sra16", 2'b00, 2'b00, 1'b0, 5'd16, 5'd17, 5'd20, 32'h8000_7FFF, 32'h4, 4'h0);
    run_legal("R3 sra8", 2'b00, 2'b00, 1'b0, 5'd2, 5'd3, 5'd15, 32'h80F1_7F05, 32'h3, 4'h0);
    run_legal("R3 srl8", 2'b01, 2'b00, 1'b0, 5'd9, 5'd9, 5'd9, 32'h80F1_7F05, 32'h7, 4'h0);
    run_legal("R3 srl16 mask", 2'b01, 2'b00, 1'b0, 5'd29, 5'd16, 5'd22, 32'hFFFF_8001, 32'hFFFF_FFFF, 4'h0);
    run_legal("R3 sra8 mask", 2'b00, 2'b00, 1'b0, 5'd4, 5'd5, 5'd6, 32'h80F1_7F05, 32'h0000_000B, 4'h0);
    run_legal("R1 sll8", 2'b10, 2'b00, 1'b0, 5'd15, 5'd2, 5'd7, 32'h8123_45FF, 32'h2, 4'h0);
  endtask

  task automatic t_round;
    run_legal("R5 rnd sra16", 2'b00, 2'b01, 1'b0, 5'd18, 5'd18, 5'd18, 32'hFFFF_0003, 32'h1, 4'h0);
    chk("R5 rnd sra16 literal", result, 32'h0000_0002);
    run_legal("R5 rnd srl8", 2'b01, 2'b01, 1'b0, 5'd3, 5'd3, 5'd3, 32'hFF07_0B81, 32'h2, 4'h0);
    run_legal("R5 rnd zero amt", 2'b00, 2'b01, 1'b0, 5'd20, 5'd21, 5'd22, 32'h8001_7FFF, 32'h0, 4'h0);
    chk("R5 rnd zero literal", result, 32'h8001_7FFF);
  endtask

  task automatic t_sat;
    run_legal("R6 sat16", 2'b10, 2'b01, 1'b0, 5'd16, 5'd16, 5'd16, 32'h4000_C000, 32'h1, 4'h0);
    chk("R6 sat16 literal", result, 32'h7FFF_8000);
    chk("R6 sat16 flag", 32'(sat), 32'd1);
    run_legal("R6 sat8 neg", 2'b10, 2'b01, 1'b0, 5'd2, 5'd2, 5'd2, 32'h0102_BF03, 32'h2, 4'h0);
    run_legal("R6 sat8 none", 2'b10, 2'b01, 1'b0, 5'd2, 5'd2, 5'd2, 32'h0102_F003, 32'h2, 4'h0);
    run_legal("R7 plain sll16", 2'b10, 2'b00, 1'b0, 5'd16, 5'd16, 5'd16, 32'h4000_C000, 32'h1, 4'h0);
    chk("R7 plain literal", result, 32'h8000_8000);
    chk("R7 plain sat", 32'(sat), 32'd0);
  endtask

  task automatic t_imm;
    run_legal("R4 imm16", 2'b00, 2'b00, 1'b1, 5'd24, 5'd25, 5'd31, 32'h8000_7FF0, 32'hFFFF_FFFF, 4'h2);
    run_legal("R4 imm8", 2'b01, 2'b01, 1'b1, 5'd8, 5'd10, 5'd0, 32'h7F80_0106, 32'h0000_0007, 4'h1);
  endtask

  task automatic t_illegal;
    run_illegal("R2 rd low", 2'b00, 2'b00, 1'b0, 5'd1, 5'd1, 5'd1);
    run_illegal("R2 rd high", 2'b00, 2'b00, 1'b0, 5'd30, 5'd30, 5'd30);
    run_illegal("R1 mixed", 2'b10, 2'b01, 1'b0, 5'd16, 5'd3, 5'd16);
    run_illegal("R1 src2 checked", 2'b01, 2'b00, 1'b0, 5'd5, 5'd5, 5'd31);
    run_illegal("R2 kind rsv", 2'b11, 2'b00, 1'b0, 5'd5, 5'd5, 5'd5);
    run_illegal("R2 mode hi", 2'b00, 2'b10, 1'b0, 5'd20, 5'd20, 5'd20);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    run_legal("R8 setup", 2'b10, 2'b01, 1'b0, 5'd16, 5'd16, 5'd16, 32'h4000_C000, 32'h1, 4'h0);
    chk("R8 out_valid high", 32'(out_valid), 32'd1);
    prev = result;
    opa = 32'h1234_5678;
    opb = 32'h3;
    @(negedge clk);
    chk("R8 out_valid low", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R8 result held", result, prev);
    chk("R8 sat held", 32'(sat), 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    kind = '0; mode = '0; use_imm = 1'b0;
    dst_idx = 5'd2; src1_idx = 5'd2; src2_idx = 5'd2;
    opa = '0; opb = '0; imm = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_kinds();
    t_round();
    t_sat();
    t_imm();
    t_illegal();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule